// File: doc/BRIEF.md
# Serial LCD Command and Data Framer

This block takes one write request at a time and sends it over a three-wire synchronous serial link (clock, data out, active-low select) to a character/graphics LCD controller. Such a controller wants every byte it receives split in two. A request in encoded mode carries between 1 and `MAX_BYTES` payload bytes and a register-select flag. The block builds a frame from it: a sync byte that carries the direction and register-select bits, then every payload byte expanded into a high-nibble byte and a low-nibble byte. A single instruction is an encoded request of length one with register-select low. A display-data burst is an encoded request with register-select high.

A raw mode sends the payload bytes exactly as given, with no sync byte and no expansion. A sequencer uses it for address frames that it has already formatted. The serial clock comes from the system clock through a divider of `HALF_DIV` system cycles per half period. Bits go out most significant first. The block raises `busy` for the whole transfer and pulses `done` when the last bit has been sent. Delays between commands are left to the sequencer.

Top module: `lcd_serial_framer`

## Requirements
- R1: After reset `spi_cs_n` is 1, and `spi_sclk`, `spi_mosi`, `busy` and `done` are 0.
- R2: An encoded frame starts with the sync byte 8'b11111_0_S_0, where S is `req_rs`. The direction bit (bit 2) is always 0, since the link only writes.
- R3: Each payload byte B is sent as two bytes, first {B[7:4],4'b0000} and then {B[3:0],4'b0000}. Payload byte k is `req_data[8k+7:8k]`, and byte 0 goes first.
- R4: An encoded frame of L payload bytes is 1+2L bytes long. An instruction (L=1) is 3 bytes and a full 16-byte burst is 33 bytes.
- R5: With `req_raw`=1 exactly L bytes are sent, each one unchanged, with no sync byte.
- R6: Bits go out MSB first. `spi_sclk` idles low. Each half period lasts `HALF_DIV` clock cycles. `spi_mosi` changes only when `spi_sclk` falls, so it is stable while `spi_sclk` is high.
- R7: `spi_cs_n` stays low for the whole frame and goes high on the same edge as the last falling edge of `spi_sclk`. A frame of N bytes keeps `busy` high for exactly N*16*`HALF_DIV` cycles, starting from the edge that accepts it.
- R8: `done` is high for exactly one cycle, in the cycle in which `busy` first reads 0 after a frame.
- R9: A request that arrives while `busy` is high is ignored and does not alter the frame in progress.
- R10: A request whose `req_len` is 0 or greater than `MAX_BYTES` is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_raw | input | 1 | 1: send bytes verbatim; 0: sync byte plus nibble expansion |
| req_rs | input | 1 | Register-select bit placed in the sync byte |
| req_len | input | $clog2(MAX_BYTES+1) | Payload byte count, 1..MAX_BYTES |
| req_data | input | MAX_BYTES*8 | Payload, byte 0 in bits 7:0 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_cs_n | output | 1 | Active-low select, low for the whole frame |

## Verification
The hardest case to reach from the ports is a new request that lands in the middle of a frame, after some bits have already gone out. To create it, the bench raises `req_valid` with different data a fixed number of cycles after acceptance. It then checks that the received bit stream and the busy length still match the first request alone. The bench also holds a receiver that samples `spi_mosi` on each rising serial clock. Every cycle it checks the idle level of the clock, that data holds still while the clock is high, and that `done` lasts one cycle. The full 33-byte burst is exercised to cover the largest frame length.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;

    localparam logic [7:0] SYNC_ONES = 8'hF8;
    localparam logic [7:0] DIR_READ  = 8'h04;
    localparam logic [7:0] SEL_DATA  = 8'h02;

    typedef enum logic {
        FRAME_ENCODED = 1'b0,
        FRAME_RAW     = 1'b1
    } frame_kind_e;

    typedef struct packed {
        logic sclk;
        logic mosi;
        logic cs_n;
    } link_pins_t;

    // Writes only: the direction bit never gets set.
    function automatic logic [7:0] sync_byte(input logic rs);
        return SYNC_ONES | (rs ? SEL_DATA : 8'h00);
    endfunction

    function automatic logic [7:0] upper_half(input logic [7:0] b);
        return {b[7:4], 4'b0000};
    endfunction

    function automatic logic [7:0] lower_half(input logic [7:0] b);
        return {b[3:0], 4'b0000};
    endfunction

endpackage

// File: rtl/lcdf_frame_builder.sv
module lcdf_frame_builder
    import lcdf_pkg::*;
#(
    parameter int MAX_BYTES   = 16,
    parameter int LEN_W       = $clog2(MAX_BYTES + 1),
    parameter int FRAME_BYTES = 1 + 2 * MAX_BYTES,
    parameter int CNT_W       = $clog2(FRAME_BYTES + 1)
) (
    input  frame_kind_e              kind,
    input  logic                     rs,
    input  logic [LEN_W-1:0]         len,
    input  logic [MAX_BYTES*8-1:0]   payload,
    output logic [FRAME_BYTES*8-1:0] frame,
    output logic [CNT_W-1:0]         frame_bytes,
    output logic                     len_ok
);
    localparam int FW = FRAME_BYTES * 8;

    logic [FW-1:0] enc_frame;
    logic [FW-1:0] raw_frame;

    // Frame byte k sits at bits [FW-1-8k -: 8], so byte 0 is shifted first.
    assign enc_frame[FW-1 -: 8] = sync_byte(rs);
    assign raw_frame[FW-8*MAX_BYTES-1:0] = '0;

    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
        assign enc_frame[FW-1-8*(1+2*i) -: 8] = upper_half(payload[8*i +: 8]);
        assign enc_frame[FW-1-8*(2+2*i) -: 8] = lower_half(payload[8*i +: 8]);
        assign raw_frame[FW-1-8*i -: 8]       = payload[8*i +: 8];
    end

    always_comb begin
        len_ok = (len != '0) && (int'(len) <= MAX_BYTES);
        if (kind == FRAME_RAW) begin
            frame       = raw_frame;
            frame_bytes = CNT_W'(len);
        end else begin
            frame       = enc_frame;
            frame_bytes = CNT_W'(1) + (CNT_W'(len) << 1);
        end
    end

endmodule

// File: rtl/lcdf_shifter.sv
module lcdf_shifter
    import lcdf_pkg::*;
#(
    parameter int FRAME_BYTES = 33,
    parameter int HALF_DIV    = 2,
    parameter int CNT_W       = $clog2(FRAME_BYTES + 1),
    parameter int BIT_W       = CNT_W + 3,
    parameter int DIV_W       = $clog2(HALF_DIV) + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [FRAME_BYTES*8-1:0] frame,
    input  logic [CNT_W-1:0]         frame_bytes,
    output logic                     busy,
    output logic                     done,
    output link_pins_t               pins
);
    localparam int FW = FRAME_BYTES * 8;

    logic [FW-1:0]    sreg;
    logic [BIT_W-1:0] bits_left;
    logic [DIV_W-1:0] div_cnt;
    logic             sclk_q;
    logic             half_end;

    assign half_end = (div_cnt == DIV_W'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            sclk_q    <= 1'b0;
            div_cnt   <= '0;
            bits_left <= '0;
            sreg      <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy      <= 1'b1;
                    sreg      <= frame;
                    bits_left <= BIT_W'(frame_bytes) << 3;
                    div_cnt   <= '0;
                    sclk_q    <= 1'b0;
                end
            end else if (!half_end) begin
                div_cnt <= div_cnt + 1'b1;
            end else begin
                div_cnt <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                end else begin
                    sclk_q <= 1'b0;
                    if (bits_left == BIT_W'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        sreg      <= sreg << 1;
                        bits_left <= bits_left - 1'b1;
                    end
                end
            end
        end
    end

    assign pins.sclk = sclk_q;
    assign pins.mosi = busy & sreg[FW-1];
    assign pins.cs_n = ~busy;

    a_r6_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
        (pins.sclk && $past(pins.sclk)) |-> $stable(pins.mosi));

    a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        pins.cs_n |-> !pins.sclk);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_with_deselect: assert property (@(posedge clk) disable iff (rst)
        done |-> (pins.cs_n && $past(busy)));

    a_r7_bits_remaining: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bits_left != '0));

endmodule

// File: rtl/lcd_serial_framer.sv
module lcd_serial_framer
    import lcdf_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    parameter int HALF_DIV  = 2,
    parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_raw,
    input  logic                   req_rs,
    input  logic [LEN_W-1:0]       req_len,
    input  logic [MAX_BYTES*8-1:0] req_data,
    output logic                   busy,
    output logic                   done,
    output logic                   spi_sclk,
    output logic                   spi_mosi,
    output logic                   spi_cs_n
);
    localparam int FRAME_BYTES = 1 + 2 * MAX_BYTES;
    localparam int CNT_W       = $clog2(FRAME_BYTES + 1);

    logic [FRAME_BYTES*8-1:0] frame;
    logic [CNT_W-1:0]         frame_bytes;
    logic                     len_ok;
    logic                     start;
    frame_kind_e              kind;
    link_pins_t               pins;

    assign kind  = req_raw ? FRAME_RAW : FRAME_ENCODED;
    assign start = req_valid & len_ok & ~busy;

    lcdf_frame_builder #(
        .MAX_BYTES  (MAX_BYTES),
        .LEN_W      (LEN_W),
        .FRAME_BYTES(FRAME_BYTES),
        .CNT_W      (CNT_W)
    ) u_build (
        .kind       (kind),
        .rs         (req_rs),
        .len        (req_len),
        .payload    (req_data),
        .frame      (frame),
        .frame_bytes(frame_bytes),
        .len_ok     (len_ok)
    );

    lcdf_shifter #(
        .FRAME_BYTES(FRAME_BYTES),
        .HALF_DIV   (HALF_DIV),
        .CNT_W      (CNT_W)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .frame      (frame),
        .frame_bytes(frame_bytes),
        .busy       (busy),
        .done       (done),
        .pins       (pins)
    );

    assign spi_sclk = pins.sclk;
    assign spi_mosi = pins.mosi;
    assign spi_cs_n = pins.cs_n;

    a_r10_bad_length_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && !len_ok) |=> !busy);

    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy || done));

endmodule

// File: tb/tb_lcd_serial_framer.sv
module tb_lcd_serial_framer;
    localparam int MAXB = 16;
    localparam int HALF = 2;
    localparam int LW   = $clog2(MAXB + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_raw   = 1'b0;
    logic              req_rs    = 1'b0;
    logic [LW-1:0]     req_len   = '0;
    logic [MAXB*8-1:0] req_data  = '0;
    logic busy, done, spi_sclk, spi_mosi, spi_cs_n;

    lcd_serial_framer #(.MAX_BYTES(MAXB), .HALF_DIV(HALF)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_raw(req_raw),
        .req_rs(req_rs), .req_len(req_len), .req_data(req_data),
        .busy(busy), .done(done), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic rx_bits[$];
    logic [7:0] exp_bytes[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Receiver: a listening device samples data on the rising serial clock.
    always @(posedge spi_sclk) if (!spi_cs_n) rx_bits.push_back(spi_mosi);

    // Per-cycle reference checks on the link behaviour.
    logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_done = 1'b0;
    int   high_run = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (spi_cs_n && spi_sclk)
                check(0, "R6", "sclk high while deselected", 1, 0);
            if (spi_sclk && prev_sclk && spi_mosi != prev_mosi)
                check(0, "R6", "mosi moved while sclk high", int'(spi_mosi), int'(prev_mosi));
            if (done && prev_done)
                check(0, "R8", "done wider than one cycle", 2, 1);
            if (busy == spi_cs_n)
                check(0, "R7", "busy vs cs_n", int'(busy), int'(!spi_cs_n));
            if (spi_sclk) high_run++;
            else begin
                if (prev_sclk)
                    check(high_run == HALF, "R6", "sclk high length", high_run, HALF);
                high_run = 0;
            end
        end
        prev_sclk = spi_sclk;
        prev_mosi = spi_mosi;
        prev_done = done;
    end

    function automatic void build_expect(input bit raw, input bit rs, input int len,
                                         input logic [MAXB*8-1:0] d);
        exp_bytes.delete();
        if (!raw) exp_bytes.push_back({5'b11111, 1'b0, rs, 1'b0});
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = d[8*i +: 8];
            if (raw) exp_bytes.push_back(b);
            else begin
                exp_bytes.push_back({b[7:4], 4'h0});
                exp_bytes.push_back({b[3:0], 4'h0});
            end
        end
    endfunction

    task automatic run_frame(input bit raw, input bit rs, input int len,
                             input logic [MAXB*8-1:0] d, input bit intrude,
                             input string req);
        int n;
        int nb;
        rx_bits.delete();
        build_expect(raw, rs, len, d);
        nb = exp_bytes.size();
        @(negedge clk);
        req_valid = 1'b1; req_raw = raw; req_rs = rs; req_len = LW'(len); req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy && !spi_cs_n, "R7", "busy/select after accept", int'(busy), 1);
        n = 0;
        while (busy && n < 100000) begin
            if (intrude && n == 20) begin
                req_valid = 1'b1; req_raw = 1'b1; req_rs = 1'b1;
                req_len = LW'(2); req_data = {MAXB{8'hA5}};
            end else if (intrude && n == 21) begin
                req_valid = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        check(n == nb * 16 * HALF, "R7", "busy cycles", n, nb * 16 * HALF);
        check(done === 1'b1, "R8", "done at end", int'(done), 1);
        check(rx_bits.size() == nb * 8, req, "bit count", rx_bits.size(), nb * 8);
        if (rx_bits.size() == nb * 8) begin
            for (int k = 0; k < nb; k++) begin
                logic [7:0] got;
                for (int j = 0; j < 8; j++) got[7-j] = rx_bits[8*k + j];
                check(got == exp_bytes[k], req, $sformatf("byte %0d", k),
                      int'(got), int'(exp_bytes[k]));
            end
        end
        @(negedge clk);
        check(!done && !busy, "R8", "done cleared", int'(done), 0);
    endtask

    task automatic try_ignored(input int len);
        rx_bits.delete();
        @(negedge clk);
        req_valid = 1'b1; req_raw = 1'b0; req_rs = 1'b1; req_len = LW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && spi_cs_n, "R10", $sformatf("len %0d busy", len), int'(busy), 0);
        check(rx_bits.size() == 0, "R10", "bits sent", rx_bits.size(), 0);
    endtask

    initial begin
        logic [MAXB*8-1:0] pat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(spi_cs_n && !spi_sclk && !spi_mosi && !busy && !done, "R1",
              "reset state", {spi_cs_n, spi_sclk, spi_mosi, busy, done}, 5'b10000);

        // Instruction frame (R2, R3, R4)
        pat = '0; pat[7:0] = 8'h36;
        run_frame(0, 0, 1, pat, 0, "R3");
        // Short data burst with RS set (R2)
        pat = '0; pat[23:0] = 24'h5A_C3_01;
        run_frame(0, 1, 3, pat, 0, "R2");
        // Full 16-byte burst, 33 bytes on the wire (R4)
        for (int i = 0; i < MAXB; i++) pat[8*i +: 8] = 8'(i * 17 + 3);
        run_frame(0, 1, MAXB, pat, 0, "R4");
        // Raw pre-formatted address frame (R5)
        pat = '0; pat[39:0] = 40'h80_00_20_60_F8;
        run_frame(1, 0, 5, pat, 0, "R5");
        // Request arriving mid-frame must be dropped (R9)
        pat = '0; pat[15:0] = 16'h9E_0C;
        run_frame(0, 0, 2, pat, 1, "R9");
        // Illegal lengths (R10)
        try_ignored(0);
        try_ignored(MAXB + 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule